// File: doc/BRIEF.md
# Interrupt Status and Vectoring Controller

This block holds the interrupt status and control byte of a small 8-bit processor core and turns pending interrupts into vector addresses. It watches three single-cycle event strobes: an edge on a first external pin, a timer overflow and an edge on a second external pin. It also reduces a vector of peripheral request flags, each gated by its own peripheral enable, into one summary flag. Software reads and writes the status byte through a simple register port. A separate global-disable input masks every request.

When an enabled flag is pending and interrupts are globally allowed, the block raises a request to the core. The core answers with a one-cycle acknowledge. On that acknowledge the block latches the vector of the winning source. It also clears that source's flag in hardware, except for the peripheral summary, which only follows the peripheral flags. Suppose software clears an enable in the same cycle that its source fires while interrupts are allowed. The block then remembers that race and sends the core to the reset address, ahead of every other source.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the status byte reads 00h, no request is raised and the latched vector is 00h.
- R2: The event flags set when their event arrives, whatever the source enable and the global disable: the first-pin flag at bit 4, the timer flag at bit 5 and the second-pin flag at bit 6.
- R3: The request is high only while a race is pending, or while the global disable is 0 and at least one flag is 1 with its enable (bit 0 first pin, bit 1 timer, bit 2 second pin, bit 3 peripheral) also 1.
- R4: Bit 7 reads as the OR over all peripheral flags, each ANDed with its peripheral enable. Register writes leave bit 7 unchanged.
- R5: An acknowledge while the request is high latches the vector, which appears on the vector output from the next cycle: 08h for the first pin, 10h for the timer, 18h for the second pin and 20h for the peripheral summary.
- R6: The acknowledge clears the flag of the vectored first-pin, timer or second-pin source. It never clears the peripheral summary.
- R7: When several enabled flags are pending, the first pin wins, then the timer, then the second pin, then the peripheral summary.
- R8: A register write and an event on the same flag in the same cycle leave the flag set.
- R9: Suppose a source fires (for the peripheral source: its summary is 1) in the same cycle that a write turns its enable from 1 to 0, with the global disable at 0. The block then raises a request whose acknowledge latches vector 00h. This request ranks above all others, and its acknowledge clears no flag.
- R10: An acknowledge while the request is low changes neither the vector output nor the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Writes reg_wr_data into bits 6..0 of the status byte |
| reg_wr_data | input | 8 | Write data; bit 7 is ignored |
| reg_rd_data | output | 8 | Current status byte |
| glb_dis | input | 1 | Global interrupt disable, 1 masks all requests |
| ev_pin_a | input | 1 | One-cycle edge strobe from the first external pin |
| ev_timer | input | 1 | One-cycle timer overflow strobe |
| ev_pin_b | input | 1 | One-cycle edge strobe from the second external pin |
| periph_flags | input | NUM_PERIPH | Peripheral request flags |
| periph_enables | input | NUM_PERIPH | Peripheral enable bits |
| irq_req | output | 1 | Interrupt request to the core |
| irq_ack | input | 1 | One-cycle acknowledge from the core |
| irq_vector | output | VEC_W | Vector latched on the last accepted acknowledge |

## Verification
The bench builds the block with NUM_PERIPH set to 4 and keeps the 8-bit vector width. With only four peripheral lines, each flag and enable pairing can be driven on its own. The bench can then show that one masked peripheral keeps bit 7 low while a matching enabled one raises it. It can also make the peripheral summary fire in the very cycle its enable is cleared, which is the race case. The default vector width still holds the top vector 20h, so all five vector values are visible at the port.

// File: rtl/irqv_pkg.sv
// Package irqv_pkg
// Shared layout of the status byte and source indexing for the interrupt
// vectoring controller. Source index order is also priority order.
package irqv_pkg;

    localparam int NUM_EDGE = 3;            // pin A, timer, pin B
    localparam int NUM_SRC  = NUM_EDGE + 1; // plus peripheral summary

    localparam int SRC_PIN_A  = 0;
    localparam int SRC_TIMER  = 1;
    localparam int SRC_PIN_B  = 2;
    localparam int SRC_PERIPH = 3;

    // Status byte image, most significant field first
    typedef struct packed {
        logic                periph_flag;
        logic [NUM_EDGE-1:0] edge_flag;
        logic                periph_en;
        logic [NUM_EDGE-1:0] edge_en;
    } stat_byte_t;

endpackage

// File: rtl/irqv_periph_reduce.sv
// Module irqv_periph_reduce
// Folds the peripheral flags, each masked by its enable, into one summary.
// Assumes flags and enables are level signals held by the peripherals.
module irqv_periph_reduce #(
    parameter int NUM_PERIPH = 8
) (
    input  logic [NUM_PERIPH-1:0] flags,
    input  logic [NUM_PERIPH-1:0] enables,
    output logic                  any_pending
);

    logic [NUM_PERIPH-1:0] masked;

    // Gate each peripheral flag with its enable, then OR them together
    always_comb begin
        masked      = flags & enables;
        any_pending = |masked;
    end

endmodule

// File: rtl/irqv_flag_bank.sv
// Module irqv_flag_bank
// Holds the three event flags, the four enables and the pending race marker.
// Update order per flag: software write, then hardware clear on vectoring,
// then hardware set on event (the event always wins).
// Assumes event inputs are single-cycle strobes.
module irqv_flag_bank
    import irqv_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    input  logic [NUM_EDGE-1:0] edge_ev,
    input  logic                periph_any,
    input  logic                glb_dis,
    input  logic [NUM_EDGE-1:0] take_edge,
    input  logic                race_take,
    output logic [NUM_EDGE-1:0] flags,
    output logic [NUM_SRC-1:0]  enables,
    output logic                race_pend
);

    stat_byte_t            wr_img;
    logic [NUM_SRC-1:0]    fire;
    logic [NUM_SRC-1:0]    en_drop;
    logic                  race_hit;

    assign wr_img = stat_byte_t'(wr_data);

    // Per-source flag storage with write, hardware clear and set priority
    for (genvar i = 0; i < NUM_EDGE; i++) begin : g_flag
        logic nxt;

        // Resolve the next value of this flag
        always_comb begin
            nxt = flags[i];
            if (wr_en)        nxt = wr_img.edge_flag[i];
            if (take_edge[i]) nxt = 1'b0;
            if (edge_ev[i])   nxt = 1'b1;
        end

        // Register this flag
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= nxt;
        end
    end

    // Enable register, loaded only by software
    always_ff @(posedge clk) begin
        if (!rst_n)     enables <= '0;
        else if (wr_en) enables <= {wr_img.periph_en, wr_img.edge_en};
    end

    // Detect a source firing in the cycle its enable goes from 1 to 0
    always_comb begin
        fire     = {periph_any, edge_ev};
        en_drop  = wr_en ? (enables & ~{wr_img.periph_en, wr_img.edge_en}) : '0;
        race_hit = !glb_dis && |(fire & en_drop);
    end

    // Remember a race until the core takes the reset vector
    always_ff @(posedge clk) begin
        if (!rst_n)         race_pend <= 1'b0;
        else if (race_hit)  race_pend <= 1'b1;
        else if (race_take) race_pend <= 1'b0;
    end

endmodule

// File: rtl/irqv_prio_sel.sv
// Module irqv_prio_sel
// Fixed-priority pick among pending sources (lowest index wins) and
// vector generation. A pending race overrides every source with vector 0.
module irqv_prio_sel
    import irqv_pkg::*;
#(
    parameter int VEC_W      = 8,
    parameter int VEC_STRIDE = 8
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic               race_pend,
    output logic [NUM_SRC-1:0] sel,
    output logic [VEC_W-1:0]   vec
);

    logic [NUM_SRC-1:0] win;

    // Priority chain: a source wins only if no lower index is pending
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_win
        if (i == 0) begin : g_first
            assign win[i] = pend[i];
        end else begin : g_rest
            assign win[i] = pend[i] & ~|pend[i-1:0];
        end
    end

    // Apply the race override and form the vector address
    always_comb begin
        sel = race_pend ? '0 : win;
        vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel[i]) vec = VEC_W'((i + 1) * VEC_STRIDE);
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module irq_vector_ctrl
// Interrupt status byte, request generation and vector latch for a small
// processor core. The core acknowledges with a one-cycle pulse; the vector
// is valid from the cycle after the acknowledge.
// Assumes the global disable bit is held elsewhere and driven in.
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int VEC_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [7:0]            reg_wr_data,
    output logic [7:0]            reg_rd_data,
    input  logic                  glb_dis,
    input  logic                  ev_pin_a,
    input  logic                  ev_timer,
    input  logic                  ev_pin_b,
    input  logic [NUM_PERIPH-1:0] periph_flags,
    input  logic [NUM_PERIPH-1:0] periph_enables,
    output logic                  irq_req,
    input  logic                  irq_ack,
    output logic [VEC_W-1:0]      irq_vector
);

    localparam int VEC_STRIDE = 8;

    logic                periph_any;
    logic [NUM_EDGE-1:0] flags;
    logic [NUM_SRC-1:0]  enables;
    logic                race_pend;
    logic [NUM_SRC-1:0]  pend;
    logic [NUM_SRC-1:0]  sel;
    logic [VEC_W-1:0]    sel_vec;
    logic                take;
    logic [NUM_EDGE-1:0] take_edge;
    stat_byte_t          rd_img;

    irqv_periph_reduce #(.NUM_PERIPH(NUM_PERIPH)) u_reduce (
        .flags       (periph_flags),
        .enables     (periph_enables),
        .any_pending (periph_any)
    );

    irqv_flag_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .edge_ev    ({ev_pin_b, ev_timer, ev_pin_a}),
        .periph_any (periph_any),
        .glb_dis    (glb_dis),
        .take_edge  (take_edge),
        .race_take  (take && race_pend),
        .flags      (flags),
        .enables    (enables),
        .race_pend  (race_pend)
    );

    irqv_prio_sel #(.VEC_W(VEC_W), .VEC_STRIDE(VEC_STRIDE)) u_sel (
        .pend      (pend),
        .race_pend (race_pend),
        .sel       (sel),
        .vec       (sel_vec)
    );

    // Pending sources, request and accepted-take decode
    always_comb begin
        pend      = glb_dis ? '0 : ({periph_any, flags} & enables);
        irq_req   = race_pend || (|pend);
        take      = irq_ack && irq_req;
        take_edge = take ? sel[NUM_EDGE-1:0] : '0;
    end

    // Assemble the readable status byte
    always_comb begin
        rd_img.periph_flag = periph_any;
        rd_img.edge_flag   = flags;
        rd_img.periph_en   = enables[SRC_PERIPH];
        rd_img.edge_en     = enables[NUM_EDGE-1:0];
        reg_rd_data        = rd_img;
    end

    // Latch the vector when the core accepts a request
    always_ff @(posedge clk) begin
        if (!rst_n)    irq_vector <= '0;
        else if (take) irq_vector <= sel_vec;
    end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Module irq_vector_ctrl_chk
// Property checker for irq_vector_ctrl, attached by the bind below.
module irq_vector_ctrl_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [7:0]       reg_rd_data,
    input logic             glb_dis,
    input logic             ev_pin_a,
    input logic             ev_timer,
    input logic             irq_req,
    input logic             irq_ack,
    input logic [VEC_W-1:0] irq_vector,
    input logic             race_pend
);

    // R3: no request while globally disabled unless a race waits
    p_no_req_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_dis && !race_pend) |-> !irq_req);

    // R2: a timer event always leaves its flag set
    p_timer_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_timer |=> reg_rd_data[5]);

    // R5: an accepted acknowledge yields a legal vector value
    p_vec_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (irq_vector[2:0] == 3'b000 && irq_vector <= VEC_W'(8'h20)));

    // R6: taking the first-pin vector clears its flag
    p_pin_a_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !race_pend && !glb_dis && reg_rd_data[4] && reg_rd_data[0]
         && !ev_pin_a && !reg_wr_en) |=> !reg_rd_data[4]);

    // R9: a pending race always requests
    p_race_requests_r9: assert property (@(posedge clk) disable iff (!rst_n)
        race_pend |-> irq_req);

    // R10: an acknowledge without a request leaves the vector alone
    p_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req) |=> $stable(irq_vector));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_data (reg_rd_data),
    .glb_dis     (glb_dis),
    .ev_pin_a    (ev_pin_a),
    .ev_timer    (ev_timer),
    .irq_req     (irq_req),
    .irq_ack     (irq_ack),
    .irq_vector  (irq_vector),
    .race_pend   (race_pend)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/100ps
module irq_vector_ctrl_tb;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_wr_data = '0;
    logic [7:0]    reg_rd_data;
    logic          glb_dis = 1'b0;
    logic          ev_pin_a = 1'b0, ev_timer = 1'b0, ev_pin_b = 1'b0;
    logic [NP-1:0] periph_flags = '0, periph_enables = '0;
    logic          irq_req;
    logic          irq_ack = 1'b0;
    logic [7:0]    irq_vector;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl #(.NUM_PERIPH(NP), .VEC_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .glb_dis(glb_dis), .ev_pin_a(ev_pin_a),
        .ev_timer(ev_timer), .ev_pin_b(ev_pin_b), .periph_flags(periph_flags),
        .periph_enables(periph_enables), .irq_req(irq_req), .irq_ack(irq_ack),
        .irq_vector(irq_vector)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr_en = 1'b1; reg_wr_data = d;
        cyc();
        reg_wr_en = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        cyc();
        irq_ack = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        chk("R1 status", reg_rd_data, 8'h00);
        chk("R1 req", {7'd0, irq_req}, 8'h00);
        chk("R1 vector", irq_vector, 8'h00);
    endtask

    // R2, R3: masked events still set flags; request follows masks
    task automatic t_masked();
        glb_dis = 1'b1;
        ev_timer = 1'b1; ev_pin_a = 1'b1; ev_pin_b = 1'b1;
        cyc();
        ev_timer = 1'b0; ev_pin_a = 1'b0; ev_pin_b = 1'b0;
        chk("R2 flags with enables off", reg_rd_data, 8'h70);
        chk("R3 no req enables off", {7'd0, irq_req}, 8'h00);
        wr(8'h72);
        chk("R3 no req global disable", {7'd0, irq_req}, 8'h00);
        glb_dis = 1'b0; #1;
        chk("R3 req when allowed", {7'd0, irq_req}, 8'h01);
        glb_dis = 1'b1;
        wr(8'h00);
        glb_dis = 1'b0;
    endtask

    // R4: peripheral summary bit and its read-only nature
    task automatic t_periph();
        periph_flags = 4'b0100; periph_enables = 4'b0010; #1;
        chk("R4 masked periph", reg_rd_data, 8'h00);
        periph_enables = 4'b0110; #1;
        chk("R4 enabled periph", reg_rd_data, 8'h80);
        periph_flags = 4'b0000; #1;
        wr(8'h80);
        chk("R4 write ignores bit7", reg_rd_data, 8'h00);
    endtask

    // R5, R6: each source alone, vector and hardware clear
    task automatic t_single();
        wr(8'h11); ack();
        chk("R5 pin A vector", irq_vector, 8'h08);
        chk("R6 pin A cleared", reg_rd_data, 8'h01);
        wr(8'h22); ack();
        chk("R5 timer vector", irq_vector, 8'h10);
        chk("R6 timer cleared", reg_rd_data, 8'h02);
        wr(8'h44); ack();
        chk("R5 pin B vector", irq_vector, 8'h18);
        chk("R6 pin B cleared", reg_rd_data, 8'h04);
        wr(8'h08); periph_flags = 4'b0001; periph_enables = 4'b0001; #1;
        ack();
        chk("R5 periph vector", irq_vector, 8'h20);
        chk("R6 periph kept", reg_rd_data, 8'h88);
        periph_flags = '0; periph_enables = '0;
        wr(8'h00);
    endtask

    // R7: priority with all sources pending
    task automatic t_prio();
        glb_dis = 1'b1;
        wr(8'h7F); periph_flags = 4'b1000; periph_enables = 4'b1000;
        glb_dis = 1'b0; #1;
        ack(); chk("R7 first pin A", irq_vector, 8'h08);
        ack(); chk("R7 then timer", irq_vector, 8'h10);
        ack(); chk("R7 then pin B", irq_vector, 8'h18);
        ack(); chk("R7 then periph", irq_vector, 8'h20);
        chk("R7 flags drained", reg_rd_data, 8'h8F);
        periph_flags = '0; #1;
        chk("R7 req drops", {7'd0, irq_req}, 8'h00);
        wr(8'h00);
    endtask

    // R8: event beats software write on the same flag
    task automatic t_set_wins();
        wr(8'h70);
        reg_wr_en = 1'b1; reg_wr_data = 8'h00; ev_pin_a = 1'b1;
        cyc();
        reg_wr_en = 1'b0; ev_pin_a = 1'b0;
        chk("R8 set beats write", reg_rd_data, 8'h10);
        wr(8'h00);
    endtask

    // R9: enable-clear race diverts to vector 00h; R10 ignored acknowledge
    task automatic t_race();
        wr(8'h02);
        reg_wr_en = 1'b1; reg_wr_data = 8'h00; ev_timer = 1'b1;
        cyc();
        reg_wr_en = 1'b0; ev_timer = 1'b0;
        chk("R9 race requests", {7'd0, irq_req}, 8'h01);
        chk("R9 flag set enable off", reg_rd_data, 8'h20);
        ack();
        chk("R9 reset vector", irq_vector, 8'h00);
        chk("R9 request gone", {7'd0, irq_req}, 8'h00);
        chk("R9 no flag cleared", reg_rd_data, 8'h20);
        // Same race through the peripheral summary
        wr(8'h11); ack();
        chk("R10 setup vector", irq_vector, 8'h08);
        periph_flags = 4'b0010; periph_enables = 4'b0010;
        wr(8'h08);
        chk("R9 periph req", {7'd0, irq_req}, 8'h01);
        wr(8'h00);
        chk("R9 periph race held", {7'd0, irq_req}, 8'h01);
        ack();
        chk("R9 periph race vector", irq_vector, 8'h00);
        periph_flags = '0; periph_enables = '0;
        wr(8'h11); ack();
        wr(8'h01);
        ack();
        chk("R10 vector unchanged", irq_vector, 8'h08);
        chk("R10 status unchanged", reg_rd_data, 8'h01);
    endtask

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_masked();
        t_periph();
        t_single();
        t_prio();
        t_set_wins();
        t_race();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule